// File: doc/BRIEF.md
# Sectioned March X Memory Self-Test Controller

This controller tests a word-wide, single-port synchronous SRAM with the March X algorithm. It works on one address section per request, so the memory can go on holding live data between requests. Each `start` pulse tests the section chosen by an internal pointer. When the test ends, the controller pulses `done`, reports pass or fail, and moves the pointer on to the next section. After the last section the pointer wraps to section 0.

The first section is a scratch area and holds no live data. It is tested directly. Every other section is handled in three steps:

- its words are copied into the scratch area;
- the March sequence runs over the section, once for each data background;
- the saved words are written back.

Each section reaches a few words back into the previous section. This overlap lets coupling faults that straddle a section boundary be seen. The scratch area is enlarged by the overlap so that it can hold any section.

The SRAM returns read data one cycle after a read is issued. Sharing the SRAM with other memory users is the job of the surrounding logic.

Top module: `mbist_sectioned`

## Requirements
- R1: A `start` seen while idle begins a test of section `sec_idx`. `busy` is high from the next cycle until the result cycle. In the result cycle `done` is high for exactly one cycle and `busy` is low.
- R2: Let S = ceil(DEPTH/NSEC). The section ranges are:
  - section 0: words 0 to S+OVL-1;
  - section 1: from word S+OVL;
  - section k ≥ 2: from word k·S-OVL;
  - every section k ≥ 1 ends at min((k+1)·S, DEPTH)-1, so the last section may be shorter.
- R3: For a section k ≠ 0, the save step copies words in ascending order. For each offset i it reads word lo+i in one cycle and writes that word to scratch address i in the next cycle.
- R4: Element 1 writes the background to every word of the section, in ascending order, one word per cycle.
- R5: Element 2 runs in ascending order, two cycles per word. The first cycle reads the word. The second cycle compares the read data with the background and writes the inverted background.
- R6: Element 3 runs in descending order, two cycles per word. It reads the word, expects the inverted background, and writes the background.
- R7: Element 4 runs in ascending order, two cycles per word. It reads the word, then compares it with the background in the next cycle. The memory is idle in that compare cycle.
- R8: With MULTI_BG=1, elements 1 to 4 run once for each byte background, in the order 0x00, 0x55, 0xAA, 0x33, 0xCC, 0x0F, 0xF0. Bit j of a word takes bit j mod 8 of the background.
- R9: Section 0 is tested with no save step and no restore step.
- R10: At the first compare mismatch the March sequence stops and `fail` rises.
  - `fail_addr` latches the failing word and `fail_elem` latches the element number (2, 3 or 4).
  - The write of the failing cycle still takes place.
  - The restore still runs, and `pass` stays low.
  - `fail` holds until the next accepted `start`.
- R11: The restore step runs in ascending order. For each offset i it reads scratch address i, then writes that word to lo+i. A fault-free section therefore ends with its original contents.
- R12: After each `done`, `sec_idx` advances by one. It wraps from NSEC-1 to 0.
- R13: After reset, `busy`, `done`, `pass`, `fail` and `mem_en` are low and `sec_idx` is 0.
- R14: A `start` that arrives while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a test of the current section |
| busy | output | 1 | A section test is in progress |
| done | output | 1 | One-cycle pulse marking the result cycle |
| pass | output | 1 | High with `done` when no mismatch was found |
| fail | output | 1 | A mismatch was found in the current or last run |
| fail_addr | output | AW | Word address of the first mismatch |
| fail_elem | output | 3 | March element number of the first mismatch |
| sec_idx | output | SW | Section that the next request will test |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable (valid with `mem_en`) |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, one cycle after a read |

## Verification
The bench builds the controller with DEPTH=30, NSEC=4, OVL=2, DW=8 and MULTI_BG=1. These values give:

- a 10-word scratch area;
- a shortened second section (words 10–15);
- a third section (words 14–23) that overlaps the second;
- a last section (words 22–29) that is shorter than the others.

All seven backgrounds run, and the pointer wraps. A stuck-at-1 bit placed at word 23 lies in the overlap of two sections, so both of those sections must fail at the same word. A `start` pulse is also injected in the middle of a run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_MARCH,
    ST_REST,
    ST_FIN
  } mbist_st_e;

  // nominal section pitch
  function automatic int pitch(int depth, int nsec);
    return (depth + nsec - 1) / nsec;
  endfunction

  // first word of section k (scratch area grows by ovl, section 1 shrinks)
  function automatic int sect_lo(int k, int s, int ovl);
    if (k == 0) return 0;
    if (k == 1) return s + ovl;
    return k * s - ovl;
  endfunction

  // last word of section k
  function automatic int sect_hi(int k, int s, int ovl, int depth);
    int e;
    if (k == 0) return s + ovl - 1;
    e = (k + 1) * s;
    if (e > depth) e = depth;
    return e - 1;
  endfunction

  // byte background number i
  function automatic logic [7:0] bg_byte(int i);
    case (i)
      1: return 8'h55;
      2: return 8'hAA;
      3: return 8'h33;
      4: return 8'hCC;
      5: return 8'h0F;
      6: return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mbist_geom.sv
module mbist_geom
  import mbist_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NSEC  = 4,
  parameter int OVL   = 2,
  parameter int AW    = 5,
  parameter int SW    = 2
) (
  input  logic [SW-1:0] sec,
  output logic [AW-1:0] lo,
  output logic [AW:0]   len
);
  localparam int S = pitch(DEPTH, NSEC);

  int lo_i, hi_i;

  always_comb begin
    lo_i = sect_lo(int'(sec), S, OVL);
    hi_i = sect_hi(int'(sec), S, OVL, DEPTH);
    lo   = AW'(lo_i);
    len  = (AW+1)'(hi_i - lo_i + 1);
  end
endmodule

// File: rtl/mbist_bgsel.sv
module mbist_bgsel
  import mbist_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    bgi,
  output logic [DW-1:0] bg
);
  logic [7:0] pat;

  always_comb begin
    pat = bg_byte(int'(bgi));
    for (int j = 0; j < DW; j++) bg[j] = pat[j % 8];
  end
endmodule

// File: rtl/mbist_sectioned.sv
module mbist_sectioned
  import mbist_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int NSEC     = 4,
  parameter int OVL      = 2,
  parameter int DW       = 8,
  parameter bit MULTI_BG = 1'b1,
  localparam int AW  = $clog2(DEPTH),
  localparam int SW  = $clog2(NSEC),
  localparam int NBG = MULTI_BG ? 7 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    fail_elem,
  output logic [SW-1:0] sec_idx,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  mbist_st_e     st;
  logic          ph;
  logic [AW-1:0] idx;
  logic [1:0]    elem;
  logic [2:0]    bgi;
  logic [SW-1:0] sec;
  logic          fail_r;

  logic [AW-1:0] lo;
  logic [AW:0]   len;
  logic [DW-1:0] bg;
  logic [DW-1:0] exp_word;
  logic [AW:0]   moff;

  // named internal events
  logic last_word, mismatch, sec_is_buf, in_copy, accept;

  mbist_geom #(.DEPTH(DEPTH), .NSEC(NSEC), .OVL(OVL), .AW(AW), .SW(SW)) u_geom (
    .sec(sec), .lo(lo), .len(len)
  );

  mbist_bgsel #(.DW(DW)) u_bg (.bgi(bgi), .bg(bg));

  assign last_word  = ({1'b0, idx} == len - 1'b1);
  assign sec_is_buf = (sec == '0);
  assign in_copy    = (st == ST_SAVE) || (st == ST_REST);
  assign accept     = start && (st == ST_IDLE);
  assign mismatch   = (st == ST_MARCH) && ph && (elem != 2'd0) && (mem_rdata != exp_word);

  assign busy    = (st != ST_IDLE) && (st != ST_FIN);
  assign done    = (st == ST_FIN);
  assign pass    = done && !fail_r;
  assign fail    = fail_r;
  assign sec_idx = sec;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    exp_word  = bg;
    moff      = (elem == 2'd2) ? (len - 1'b1 - {1'b0, idx}) : {1'b0, idx};
    case (st)
      ST_SAVE: begin
        mem_en    = 1'b1;
        mem_we    = ph;
        mem_addr  = ph ? idx : lo + idx;
        mem_wdata = mem_rdata;
      end
      ST_REST: begin
        mem_en    = 1'b1;
        mem_we    = ph;
        mem_addr  = ph ? lo + idx : idx;
        mem_wdata = mem_rdata;
      end
      ST_MARCH: begin
        mem_addr = AW'({1'b0, lo} + moff);
        case (elem)
          2'd0: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = bg; end
          2'd1: begin mem_en = 1'b1; mem_we = ph; mem_wdata = ~bg; exp_word = bg; end
          2'd2: begin mem_en = 1'b1; mem_we = ph; mem_wdata = bg; exp_word = ~bg; end
          default: begin mem_en = !ph; exp_word = bg; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= 1'b0;
      idx       <= '0;
      elem      <= '0;
      bgi       <= '0;
      sec       <= '0;
      fail_r    <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st     <= sec_is_buf ? ST_MARCH : ST_SAVE;
          ph     <= 1'b0;
          idx    <= '0;
          elem   <= '0;
          bgi    <= '0;
          fail_r <= 1'b0;
        end
        ST_SAVE, ST_REST: begin
          ph <= !ph;
          if (ph) begin
            if (last_word) begin
              idx <= '0;
              st  <= (st == ST_SAVE) ? ST_MARCH : ST_FIN;
            end else idx <= idx + 1'b1;
          end
        end
        ST_MARCH: begin
          if (elem == 2'd0) begin
            if (last_word) begin idx <= '0; elem <= 2'd1; end
            else idx <= idx + 1'b1;
          end else begin
            ph <= !ph;
            if (ph) begin
              if (mismatch) begin
                fail_r    <= 1'b1;
                fail_addr <= mem_addr;
                fail_elem <= {1'b0, elem} + 3'd1;
                idx       <= '0;
                st        <= sec_is_buf ? ST_FIN : ST_REST;
              end else if (last_word) begin
                idx <= '0;
                if (elem == 2'd3) begin
                  if (bgi == 3'(NBG - 1)) st <= sec_is_buf ? ST_FIN : ST_REST;
                  else begin bgi <= bgi + 1'b1; elem <= 2'd0; end
                end else elem <= elem + 1'b1;
              end else idx <= idx + 1'b1;
            end
          end
        end
        ST_FIN: begin
          st  <= ST_IDLE;
          sec <= (sec == SW'(NSEC - 1)) ? '0 : sec + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_we_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  assert_done_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_ptr_advance_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sec_idx == (($past(sec_idx) == SW'(NSEC - 1)) ? '0 : $past(sec_idx) + 1'b1)));

  assert_buf_no_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sec_idx == '0) |-> !in_copy);

  assert_addr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ({1'b0, mem_addr} < (AW+1)'(DEPTH)));

  assert_e4_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MARCH && elem == 2'd3) |-> !mem_we);

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy && !done)) |=> fail);

  assert_start_ignored_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

endmodule

// File: tb/mbist_sectioned_bench.sv
module mbist_sectioned_bench;
  localparam int D  = 30;
  localparam int NS = 4;
  localparam int OV = 2;
  localparam int FA = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass, fail;
  logic [4:0] fail_addr;
  logic [2:0] fail_elem;
  logic [1:0] sec_idx;
  logic mem_en, mem_we;
  logic [4:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] rdat;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit fault_on = 1'b0;
  bit finished = 1'b0;

  logic [7:0] smem [0:D-1];
  int mm [D];
  int snap [D];

  typedef struct { bit en; bit we; int a; int d; bit dn; int rq; } op_t;
  op_t q[$];
  bit exp_fail;
  int exp_faddr, exp_felem;

  always #5 clk = ~clk;

  mbist_sectioned #(.DEPTH(D), .NSEC(NS), .OVL(OV), .DW(8), .MULTI_BG(1'b1)) u_mbist_sectioned (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem), .sec_idx(sec_idx),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(rdat)
  );

  // SRAM with optional stuck-at-1 on bit 0 of word FA (seen on reads)
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) smem[mem_addr] <= mem_wdata;
      else rdat <= (fault_on && int'(mem_addr) == FA) ? (smem[mem_addr] | 8'h01) : smem[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int blo(int k);
    int s = (D + NS - 1) / NS;
    return (k == 0) ? 0 : (k == 1) ? s + OV : k * s - OV;
  endfunction

  function automatic int bhi(int k);
    int s = (D + NS - 1) / NS;
    int e = ((k + 1) * s > D) ? D : (k + 1) * s;
    return (k == 0) ? s + OV - 1 : e - 1;
  endfunction

  function automatic int mrd(int a);
    return (fault_on && a == FA) ? (mm[a] | 1) : mm[a];
  endfunction

  task automatic push(bit en, bit we, int a, int d, bit dn, int rq);
    op_t o;
    o.en = en; o.we = we; o.a = a; o.d = d; o.dn = dn; o.rq = rq;
    q.push_back(o);
  endtask

  task automatic check(bit ok, int rq, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // behavioural expectation of every cycle of one section test
  task automatic gen(int k);
    int lo, n, a, r, bg, nb;
    int bgl[7] = '{8'h00, 8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};
    bit bad;
    lo = blo(k); n = bhi(k) - lo + 1; bad = 1'b0; exp_fail = 1'b0;
    for (int i = 0; i < D; i++) mm[i] = int'(smem[i]);
    if (k != 0)
      for (int i = 0; i < n; i++) begin  // R3 save
        push(1, 0, lo + i, 0, 0, 3);
        push(1, 1, i, mrd(lo + i), 0, 3);
        mm[i] = mrd(lo + i);
      end
    for (int b = 0; b < 7 && !bad; b++) begin  // R8 backgrounds
      bg = bgl[b]; nb = (~bg) & 8'hFF;
      for (int i = 0; i < n; i++) begin push(1, 1, lo + i, bg, 0, 4); mm[lo + i] = bg; end  // R4
      for (int i = 0; i < n && !bad; i++) begin  // R5
        a = lo + i; r = mrd(a);
        push(1, 0, a, 0, 0, 5); push(1, 1, a, nb, 0, 5); mm[a] = nb;
        if (r != bg) begin bad = 1'b1; exp_faddr = a; exp_felem = 2; end
      end
      for (int i = n - 1; i >= 0 && !bad; i--) begin  // R6
        a = lo + i; r = mrd(a);
        push(1, 0, a, 0, 0, 6); push(1, 1, a, bg, 0, 6); mm[a] = bg;
        if (r != nb) begin bad = 1'b1; exp_faddr = a; exp_felem = 3; end
      end
      for (int i = 0; i < n && !bad; i++) begin  // R7
        a = lo + i; r = mrd(a);
        push(1, 0, a, 0, 0, 7); push(0, 0, 0, 0, 0, 7);
        if (r != bg) begin bad = 1'b1; exp_faddr = a; exp_felem = 4; end
      end
    end
    exp_fail = bad;  // R10
    if (k != 0)
      for (int i = 0; i < n; i++) begin  // R11 restore
        push(1, 0, i, 0, 0, 11);
        push(1, 1, lo + i, mrd(i), 0, 11);
        mm[lo + i] = mrd(i);
      end
    push(0, 0, 0, 0, 1, 1);
  endtask

  task automatic run_section(int k, bit poke);
    op_t e;
    bit ok;
    int i, lo, hi;
    lo = blo(k); hi = bhi(k);
    for (int j = 0; j < D; j++) snap[j] = int'(smem[j]);
    q.delete();
    gen(k);
    check(sec_idx == 2'(k), 12, "section pointer before start", int'(sec_idx), k);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    i = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      ok = (mem_en == e.en) && (mem_we == e.we) && (!e.en || int'(mem_addr) == e.a) &&
           (!e.we || int'(mem_wdata) == e.d) && (done == e.dn) && (busy == !e.dn);
      check(ok, e.rq, $sformatf("cycle %0d en/we/addr/wdata/done", i),
            {mem_en, mem_we, done, busy, 3'b0, mem_addr, mem_wdata},
            {e.en, e.we, e.dn, !e.dn, 3'b0, 5'(e.a), 8'(e.d)});
      if (e.dn) begin
        check(fail == exp_fail && pass == !exp_fail, 10, "pass/fail at done", {pass, fail}, {!exp_fail, exp_fail});
        if (exp_fail) begin
          check(int'(fail_addr) == exp_faddr, 10, "fail_addr", int'(fail_addr), exp_faddr);
          check(int'(fail_elem) == exp_felem, 10, "fail_elem", int'(fail_elem), exp_felem);
        end
      end
      start = poke && (i == 20);  // R14 start during busy
      i++;
      @(negedge clk);
    end
    start = 1'b0;
    check(sec_idx == 2'((k + 1) % NS), 12, "pointer advance", int'(sec_idx), (k + 1) % NS);
    for (int j = 0; j < D; j++)
      check(int'(smem[j]) == mm[j], 11, $sformatf("memory word %0d after run", j), int'(smem[j]), mm[j]);
    if (k != 0 && !fault_on)
      for (int j = lo; j <= hi; j++)
        check(int'(smem[j]) == snap[j], 11, $sformatf("word %0d preserved", j), int'(smem[j]), snap[j]);
  endtask

  initial begin
    for (int j = 0; j < D; j++) smem[j] = 8'((j * 37 + 5) & 8'hFF);
    repeat (3) @(negedge clk);
    // R13 reset state
    check(!busy && !done && !pass && !fail && !mem_en && sec_idx == 2'd0, 13, "reset outputs",
          {busy, done, pass, fail, mem_en, 1'b0, sec_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_section(0, 1'b0);  // R9 scratch area, no copy
    run_section(1, 1'b1);  // R2 shrunk section, R14 poke
    run_section(2, 1'b0);
    run_section(3, 1'b0);  // R2 shorter last section
    fault_on = 1'b1;       // stuck bit in the overlap of sections 2 and 3
    run_section(0, 1'b0);
    run_section(1, 1'b0);
    run_section(2, 1'b0);  // R10 fails at element 2
    run_section(3, 1'b0);  // R10 same word through the overlap
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule